// File: doc/BRIEF.md
# Microcoded Residue Arithmetic Datapath

This block evaluates a small set of fixed arithmetic functions on three 12-bit binary operands. It does the work in residue form over the fixed moduli {15, 16, 17}. A caller drives a function code with the operands and pulses `start`. The block then reads a short stored program of routing words, one per step. Each word tells every unit which source feeds each of its two operand inputs, which units capture a new value, which operand the second converter takes, and which unit reaches the output. When the program finishes, the block returns the binary result and pulses `done`.

The datapath has the following parts:

- Two binary-to-residue converters. The first always takes X. The second takes Y or Z, as the step selects.
- One modular adder, one modular subtractor and one modular multiplier. Each unit has an independent lane for every modulus.
- One residue-to-binary converter, which applies Chinese-remainder weights and then reduces modulo 4080.

Every unit output is registered at the end of a step. A unit can therefore take its own previous result as an operand. Exponentiation works this way: it loops on the multiplier.

Top module: `rns_recon_dp`

## Requirements
- R1: While reset is asserted and after it is released, `busy` and `done` are 0 and `result` is 0 until the first operation completes.
- R2: A `start` pulse seen while the block is idle is accepted: `busy` is 1 in the next cycle. A `start` seen while `busy` is 1 is ignored. Its function code and operands do not affect the running result.
- R3: Function code 0 returns ((X+Y)·Z) mod 4080.
- R4: Function code 1 returns X^Y mod 4080. The exponent is the full 12-bit Y, and Y = 0 returns 1.
- R5: Function code 2 returns (X·Y − Z) mod 4080, with negative values wrapped into 0..4079.
- R6: Function code 3 returns ((X−Y)·(X+Z)) mod 4080, with negative differences wrapped.
- R7: Operand values from 4080 to 4095 behave as their value mod 4080.
- R8: `done` is a one-cycle pulse. `result` changes only on the cycle `done` is 1 and holds its value otherwise.
- R9: Counted in clock edges after the edge that samples `start`, `done` rises after 3 edges for codes 0 and 2, after 4 edges for code 3, and after Y+2 edges for code 1.
- R10: Every lane of every unit register always holds a value below that lane's modulus (15, 16 or 17).
- R11: `result` is always below 4080.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Begin an operation when idle |
| func | input | 2 | Function code: 0 (X+Y)·Z, 1 X^Y, 2 X·Y−Z, 3 (X−Y)·(X+Z) |
| opx | input | 12 | Operand X |
| opy | input | 12 | Operand Y (also the exponent for code 1) |
| opz | input | 12 | Operand Z |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 12 | Binary result, held between operations |

## Verification
The hardest state to reach is the far end of the multiplier feedback loop. With a 4095 exponent, the repeat counter runs through its whole range before the program advances. The same path also contains the zero-exponent case, where the loop step is skipped entirely. Directed operations cover exponents 0, 1 and 4095, along with operands in the 4080..4095 alias band. A second `start` with different operands is injected mid-operation to show it has no effect. Random operations with exponents below 64 then mix all four function codes.

// File: rtl/rns_pkg.sv
package rns_pkg;
  localparam int unsigned LANES = 3;
  localparam int unsigned OPW   = 12;
  localparam int unsigned FUNCW = 2;
  localparam int unsigned STEPW = 2;
  localparam int unsigned SELW  = 3;

  function automatic int unsigned modulus(int unsigned i);
    case (i)
      0:       return 15;
      1:       return 16;
      default: return 17;
    endcase
  endfunction

  localparam int unsigned RANGE = modulus(0) * modulus(1) * modulus(2);
  localparam int unsigned RW    = $clog2(modulus(LANES-1) + 1);

  typedef logic [LANES-1:0][RW-1:0] res_vec_t;

  localparam logic [SELW-1:0] SRC_CV1  = 3'd0;
  localparam logic [SELW-1:0] SRC_CV2  = 3'd1;
  localparam logic [SELW-1:0] SRC_ADD  = 3'd2;
  localparam logic [SELW-1:0] SRC_SUB  = 3'd3;
  localparam logic [SELW-1:0] SRC_MUL  = 3'd4;
  localparam logic [SELW-1:0] SRC_ZERO = 3'd7;

  localparam int UNIT_ADD = 0;
  localparam int UNIT_SUB = 1;
  localparam int UNIT_MUL = 2;

  typedef struct packed {
    logic            rep;
    logic            last;
    logic            feed_z;
    logic [SELW-1:0] out_sel;
    logic            en_add;
    logic            en_sub;
    logic            en_mul;
    logic [SELW-1:0] add_a;
    logic [SELW-1:0] add_b;
    logic [SELW-1:0] sub_a;
    logic [SELW-1:0] sub_b;
    logic [SELW-1:0] mul_a;
    logic [SELW-1:0] mul_b;
  } uword_t;

  // Reconstruction weight for lane i: (RANGE/m) times its inverse mod m.
  function automatic int unsigned crt_weight(int unsigned i);
    int unsigned m;
    int unsigned big;
    int unsigned w;
    m   = modulus(i);
    big = RANGE / m;
    w   = 0;
    for (int unsigned k = 1; k < m; k++)
      if (((big * k) % m) == 1 && w == 0) w = big * k;
    return w;
  endfunction

  function automatic res_vec_t route(logic [SELW-1:0] sel, res_vec_t c1,
                                     res_vec_t c2, res_vec_t ad,
                                     res_vec_t sb, res_vec_t ml);
    case (sel)
      SRC_CV1: return c1;
      SRC_CV2: return c2;
      SRC_ADD: return ad;
      SRC_SUB: return sb;
      SRC_MUL: return ml;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/rns_fwd_conv.sv
module rns_fwd_conv
  import rns_pkg::*;
(
  input  logic [OPW-1:0] bin,
  output res_vec_t       res
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int unsigned M = modulus(g);
    assign res[g] = RW'(32'(bin) % M);
  end
endmodule

// File: rtl/rns_lane_unit.sv
module rns_lane_unit
  import rns_pkg::*;
#(
  parameter int KIND = UNIT_ADD
)(
  input  res_vec_t a,
  input  res_vec_t b,
  output res_vec_t y
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int unsigned M = modulus(g);
    if (KIND == UNIT_ADD) begin : g_add
      logic [RW:0] sum;
      assign sum  = {1'b0, a[g]} + {1'b0, b[g]};
      assign y[g] = (sum >= (RW+1)'(M)) ? RW'(sum - (RW+1)'(M)) : sum[RW-1:0];
    end else if (KIND == UNIT_SUB) begin : g_sub
      logic [RW:0] dif;
      assign dif  = {1'b0, a[g]} - {1'b0, b[g]};
      assign y[g] = dif[RW] ? RW'(dif + (RW+1)'(M)) : dif[RW-1:0];
    end else begin : g_mul
      logic [2*RW-1:0] prod;
      assign prod = (2*RW)'(a[g]) * (2*RW)'(b[g]);
      assign y[g] = RW'(32'(prod) % M);
    end
  end
endmodule

// File: rtl/rns_crt.sv
module rns_crt
  import rns_pkg::*;
(
  input  res_vec_t       res,
  output logic [OPW-1:0] bin
);
  logic [LANES-1:0][31:0] term;
  logic [31:0]            acc;

  for (genvar g = 0; g < LANES; g++) begin : g_term
    localparam int unsigned W = crt_weight(g);
    assign term[g] = 32'(res[g]) * W;
  end

  always_comb begin
    acc = '0;
    for (int i = 0; i < LANES; i++) acc = acc + term[i];
  end

  assign bin = OPW'(acc % RANGE);
endmodule

// File: rtl/rns_ucode_rom.sv
module rns_ucode_rom
  import rns_pkg::*;
(
  input  logic [FUNCW+STEPW-1:0] addr,
  output uword_t                 word
);
  always_comb begin
    word         = '0;
    word.add_a   = SRC_ZERO;
    word.add_b   = SRC_ZERO;
    word.sub_a   = SRC_ZERO;
    word.sub_b   = SRC_ZERO;
    word.mul_a   = SRC_ZERO;
    word.mul_b   = SRC_ZERO;
    word.out_sel = SRC_ZERO;
    case (addr)
      // code 0: (X+Y)*Z
      4'b00_00: begin word.en_add = 1'b1; word.add_a = SRC_CV1; word.add_b = SRC_CV2; end
      4'b00_01: begin word.feed_z = 1'b1; word.en_mul = 1'b1;
                      word.mul_a = SRC_ADD; word.mul_b = SRC_CV2; end
      4'b00_10: begin word.last = 1'b1; word.out_sel = SRC_MUL; end
      // code 1: X^Y, multiplier loops on itself
      4'b01_00: begin word.rep = 1'b1; word.en_mul = 1'b1;
                      word.mul_a = SRC_MUL; word.mul_b = SRC_CV1; end
      4'b01_01: begin word.last = 1'b1; word.out_sel = SRC_MUL; end
      // code 2: X*Y - Z
      4'b10_00: begin word.en_mul = 1'b1; word.mul_a = SRC_CV1; word.mul_b = SRC_CV2; end
      4'b10_01: begin word.feed_z = 1'b1; word.en_sub = 1'b1;
                      word.sub_a = SRC_MUL; word.sub_b = SRC_CV2; end
      4'b10_10: begin word.last = 1'b1; word.out_sel = SRC_SUB; end
      // code 3: (X-Y)*(X+Z)
      4'b11_00: begin word.en_sub = 1'b1; word.sub_a = SRC_CV1; word.sub_b = SRC_CV2; end
      4'b11_01: begin word.feed_z = 1'b1; word.en_add = 1'b1;
                      word.add_a = SRC_CV1; word.add_b = SRC_CV2; end
      4'b11_10: begin word.en_mul = 1'b1; word.mul_a = SRC_SUB; word.mul_b = SRC_ADD; end
      4'b11_11: begin word.last = 1'b1; word.out_sel = SRC_MUL; end
      default:  word.last = 1'b1;
    endcase
  end
endmodule

// File: rtl/rns_recon_dp.sv
module rns_recon_dp
  import rns_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [FUNCW-1:0] func,
  input  logic [OPW-1:0]   opx,
  input  logic [OPW-1:0]   opy,
  input  logic [OPW-1:0]   opz,
  output logic             busy,
  output logic             done,
  output logic [OPW-1:0]   result
);
  localparam res_vec_t ONE_RES = {LANES{RW'(1)}};

  logic [1:0] rst_pipe;
  logic       arst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign arst_n = rst_pipe[1];

  logic             busy_q, busy_n, done_q, done_n;
  logic [STEPW-1:0] pc_q, pc_n;
  logic [OPW-1:0]   cnt_q, cnt_n, res_q, res_n;
  logic [FUNCW-1:0] func_q;
  logic [OPW-1:0]   x_q, y_q, z_q;
  res_vec_t         add_q, add_n, sub_q, sub_n, mul_q, mul_n;

  uword_t   uw;
  res_vec_t cv1, cv2, add_y, sub_y, mul_y, out_res;
  logic [OPW-1:0] out_bin;
  logic     ld_op, exec;

  rns_ucode_rom i_rom (.addr({func_q, pc_q}), .word(uw));

  rns_fwd_conv i_cv1 (.bin(x_q), .res(cv1));
  rns_fwd_conv i_cv2 (.bin(uw.feed_z ? z_q : y_q), .res(cv2));

  rns_lane_unit #(.KIND(UNIT_ADD)) i_add (
    .a(route(uw.add_a, cv1, cv2, add_q, sub_q, mul_q)),
    .b(route(uw.add_b, cv1, cv2, add_q, sub_q, mul_q)),
    .y(add_y));
  rns_lane_unit #(.KIND(UNIT_SUB)) i_sub (
    .a(route(uw.sub_a, cv1, cv2, add_q, sub_q, mul_q)),
    .b(route(uw.sub_b, cv1, cv2, add_q, sub_q, mul_q)),
    .y(sub_y));
  rns_lane_unit #(.KIND(UNIT_MUL)) i_mul (
    .a(route(uw.mul_a, cv1, cv2, add_q, sub_q, mul_q)),
    .b(route(uw.mul_b, cv1, cv2, add_q, sub_q, mul_q)),
    .y(mul_y));

  assign out_res = route(uw.out_sel, cv1, cv2, add_q, sub_q, mul_q);
  rns_crt i_crt (.res(out_res), .bin(out_bin));

  assign ld_op = !busy_q && start;
  assign exec  = busy_q && (!uw.rep || (cnt_q != '0));

  always_comb begin
    busy_n = busy_q;
    done_n = 1'b0;
    pc_n   = pc_q;
    cnt_n  = cnt_q;
    res_n  = res_q;
    add_n  = add_q;
    sub_n  = sub_q;
    mul_n  = mul_q;
    if (ld_op) begin
      busy_n = 1'b1;
      pc_n   = '0;
      cnt_n  = opy;
      add_n  = '0;
      sub_n  = '0;
      mul_n  = ONE_RES;
    end else if (busy_q) begin
      if (exec && uw.en_add) add_n = add_y;
      if (exec && uw.en_sub) sub_n = sub_y;
      if (exec && uw.en_mul) mul_n = mul_y;
      if (uw.rep) begin
        if (cnt_q != '0) cnt_n = cnt_q - 1'b1;
        else             pc_n  = pc_q + 1'b1;
      end else if (uw.last) begin
        busy_n = 1'b0;
        done_n = 1'b1;
        res_n  = out_bin;
      end else begin
        pc_n = pc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      pc_q   <= '0;
      cnt_q  <= '0;
      res_q  <= '0;
      add_q  <= '0;
      sub_q  <= '0;
      mul_q  <= '0;
    end else begin
      busy_q <= busy_n;
      done_q <= done_n;
      pc_q   <= pc_n;
      cnt_q  <= cnt_n;
      res_q  <= res_n;
      add_q  <= add_n;
      sub_q  <= sub_n;
      mul_q  <= mul_n;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      func_q <= '0;
      x_q    <= '0;
      y_q    <= '0;
      z_q    <= '0;
    end else if (ld_op) begin
      func_q <= func;
      x_q    <= opx;
      y_q    <= opy;
      z_q    <= opz;
    end
  end

  assign busy   = busy_q;
  assign done   = done_q;
  assign result = res_q;
endmodule

// File: rtl/rns_recon_dp_chk.sv
module rns_recon_dp_chk
  import rns_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic [OPW-1:0] result,
  input res_vec_t       add_q,
  input res_vec_t       sub_q,
  input res_vec_t       mul_q
);
  // R11
  result_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result < OPW'(RANGE));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

  // R2
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R2
  busy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int unsigned M = modulus(g);
    // R10
    lane_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(add_q[g]) < M) && (32'(sub_q[g]) < M) && (32'(mul_q[g]) < M));
  end
endmodule

bind rns_recon_dp rns_recon_dp_chk i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .result(result), .add_q(add_q), .sub_q(sub_q), .mul_q(mul_q));

// File: tb/test_rns_recon_dp.sv
module test_rns_recon_dp;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [1:0]  func;
  logic [11:0] opx, opy, opz;
  logic        busy, done;
  logic [11:0] result;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          finished = 1'b0;

  localparam longint RNG = 4080;

  always #2 clk = ~clk;

  rns_recon_dp i_rns_recon_dp (
    .clk(clk), .rst_n(rst_n), .start(start), .func(func),
    .opx(opx), .opy(opy), .opz(opz),
    .busy(busy), .done(done), .result(result));

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint wrap(longint v);
    return ((v % RNG) + RNG) % RNG;
  endfunction

  function automatic longint model(int f, longint x, longint y, longint z);
    longint r;
    case (f)
      0: return wrap((x + y) * z);
      1: begin
        r = 1;
        for (longint i = 0; i < y; i++) r = wrap(r * x);
        return r;
      end
      2: return wrap(x * y - z);
      default: return wrap(wrap(x - y) * wrap(x + z));
    endcase
  endfunction

  function automatic int latency(int f, int y);
    case (f)
      0, 2:    return 3;
      1:       return y + 2;
      default: return 4;
    endcase
  endfunction

  function automatic string rtag(int f);
    case (f)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic run_op(input int f, input int x, input int y, input int z, input bit poke);
    longint exp;
    int     n;
    logic [11:0] held;
    exp = model(f, x, y, z);
    @(negedge clk);
    start = 1'b1; func = 2'(f); opx = 12'(x); opy = 12'(y); opz = 12'(z);
    @(negedge clk);
    start = 1'b0;
    // R2: accepted start raises busy
    check(busy === 1'b1, "R2 busy after start", longint'(busy), 1);
    n = 0;
    while (done !== 1'b1 && n < 6000) begin
      @(negedge clk);
      n++;
      if (poke && n == 1) begin
        start = 1'b1; func = ~func; opx = ~opx; opy = 12'd3; opz = ~opz;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    check(longint'(result) == exp, rtag(f), longint'(result), exp);
    if (poke) check(longint'(result) == exp, "R2 ignored start", longint'(result), exp);
    // R9 latency
    check(n == latency(f, y), "R9 latency", n, latency(f, y));
    // R11 range
    check(result < 12'd4080, "R11 range", longint'(result), 4079);
    held = result;
    @(negedge clk);
    // R8 single pulse, hold
    check(done === 1'b0, "R8 done pulse", longint'(done), 0);
    @(negedge clk);
    check(result == held, "R8 result hold", longint'(result), longint'(held));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start = 1'b0; func = '0; opx = '0; opy = '0; opz = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    check(busy === 1'b0 && done === 1'b0 && result === 12'd0, "R1 in reset", longint'(result), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && result === 12'd0, "R1 after release", longint'(result), 0);

    // directed
    run_op(0, 10, 20, 3, 1'b0);        // R3
    run_op(0, 4095, 4095, 4095, 1'b0); // R7 alias band
    run_op(1, 7, 0, 0, 1'b0);          // R4 zero exponent
    run_op(1, 1234, 1, 0, 1'b0);       // R4 exponent one
    run_op(1, 0, 5, 0, 1'b0);          // R4 zero base
    run_op(1, 3, 4095, 0, 1'b0);       // R4 full exponent
    run_op(2, 2, 3, 100, 1'b0);        // R5 negative wrap
    run_op(2, 4080, 4081, 0, 1'b0);    // R7 aliases of 0 and 1
    run_op(3, 5, 900, 11, 1'b0);       // R6 negative difference
    run_op(3, 4095, 15, 4090, 1'b0);   // R6, R7
    run_op(0, 100, 200, 300, 1'b1);    // R2 start while busy
    run_op(1, 9, 4, 0, 1'b1);          // R2 during loop

    // random mix
    for (int i = 0; i < 60; i++) begin
      int f;
      int y;
      f = int'($urandom_range(3, 0));
      y = (f == 1) ? int'($urandom_range(63, 0)) : int'($urandom_range(4095, 0));
      run_op(f, int'($urandom_range(4095, 0)), y, int'($urandom_range(4095, 0)),
             ($urandom_range(7, 0) == 0));
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule